// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Interrupts

An eight-pin general-purpose port. Software writes an output data value, a two-bit mode code shared by every pin, and a per-pin interrupt-enable mask. The mode code selects two things together: how each pin is driven (open-drain, push-pull or resistive pull-up) and which edge of the pin input raises an interrupt (rising, falling or none). The mask enables interrupts per pin. In the push-pull mode it also decides which pins keep a high-side driver. A pin with its mask bit set loses that driver and becomes open-drain, so it can still be read as an input.

Pad electrical behaviour is represented only by three control vectors per port: low-side sink enable, high-side source enable and pull-up enable. Pin inputs pass through a synchronizer. A read of the data address returns the synchronized pin levels. An edge detector compares each synchronized level with its value one cycle earlier. A two-state request machine turns any enabled edge into a one-cycle pulse on the single request output. The states are `IRQ_IDLE` and `IRQ_FIRE`. `IRQ_IDLE` moves to `IRQ_FIRE` when an enabled edge is seen. `IRQ_FIRE` stays in `IRQ_FIRE` while another enabled edge is seen and returns to `IRQ_IDLE` otherwise.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the data register holds all ones, the mode code is 00 and the mask is zero. As a result, `drv_low`, `drv_high` and `pull_up` are all zero and `irq` is low.
- R2: In every mode, a write to address 0 sets `drv_low[i]` to the inverse of data bit i. `drv_low` and `drv_high` are never both set on the same pin.
- R3: Mode code 11 (resistive) sets `pull_up[i]` to data bit i and `drv_high` to zero. In every other mode, `pull_up` is zero.
- R4: Mode code 10 sets `drv_high[i]` to data bit i when mask bit i is 0 (push-pull). It sets `drv_high[i]` to 0 when mask bit i is 1 (open-drain).
- R5: Mode codes 00 and 01 are open-drain: `drv_high` and `pull_up` are zero.
- R6: A read at address 0 returns the pin levels, not the data register. A pin change first appears in `rd_data` two clock edges after it is applied.
- R7: With mode code 00, a rising edge on a pin whose mask bit is 1 makes `irq` high for exactly one cycle, after the third clock edge following the change. A falling edge raises nothing.
- R8: With mode code 01 or 11, a falling edge on an enabled pin raises the same one-cycle pulse with the same timing. A rising edge raises nothing.
- R9: With mode code 10, no pin edge raises `irq`.
- R10: Edges on pins whose mask bit is 0 never raise `irq`.
- R11: Address 1 writes and reads the mask. Address 2 writes the mode code from `wdata[1:0]` and reads it back in bits 1:0, with the upper bits reading zero. Address 3 reads zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 data/pins, 1 mask, 2 mode, 3 unused |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| pin_in | input | 8 | Pin input levels |
| drv_low | output | 8 | Low-side sink enable per pin |
| drv_high | output | 8 | High-side source enable per pin |
| pull_up | output | 8 | Pull-up enable per pin |
| irq | output | 1 | Port interrupt request, one-cycle pulse |

## Verification
A wrong stored mode code or mask shows on the same cycle as the write completes: `drv_high` or `pull_up` takes the wrong pattern, so a single sample of the drive controls finds it. A wrong previous-level register or request state only shows when a pin moves. It shows as a pulse that is missing, extra, on the wrong edge or late, within four cycles of the change. The bench therefore samples `irq` on each of the four cycles after every pin change. An interrupt that fires in the wrong mode or for a masked pin is caught the cycle after the edge is detected.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        MODE_OD_RISE   = 2'b00,
        MODE_OD_FALL   = 2'b01,
        MODE_PUSHPULL  = 2'b10,
        MODE_RESISTIVE = 2'b11
    } port_mode_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_FIRE = 1'b1
    } irq_state_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADR_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_MODE = 2'd2;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  port_mode_e       mode,
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] drv_low,
    output logic [WIDTH-1:0] drv_high,
    output logic [WIDTH-1:0] pull_up
);
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            always_comb begin
                drv_low[i]  = ~data[i];
                drv_high[i] = 1'b0;
                pull_up[i]  = 1'b0;
                unique case (mode)
                    MODE_RESISTIVE: pull_up[i]  = data[i];
                    MODE_PUSHPULL:  drv_high[i] = data[i] & ~mask[i];
                    MODE_OD_RISE,
                    MODE_OD_FALL:   drv_high[i] = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  port_mode_e       mode,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] level,
    output logic             irq
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise, fall, armed;
    logic             hit;
    irq_state_e       state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

    always_comb begin
        unique case (mode)
            MODE_OD_RISE:   armed = rise;
            MODE_OD_FALL,
            MODE_RESISTIVE: armed = fall;
            MODE_PUSHPULL:  armed = '0;
        endcase
    end

    assign hit = |(armed & mask);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            IRQ_IDLE: state_d = hit ? IRQ_FIRE : IRQ_IDLE;
            IRQ_FIRE: state_d = hit ? IRQ_FIRE : IRQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_IDLE: irq = 1'b0;
            IRQ_FIRE: irq = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  drv_low,
    output logic [WIDTH-1:0]  drv_high,
    output logic [WIDTH-1:0]  pull_up,
    output logic              irq
);
    localparam int MODE_PAD = WIDTH - 2;

    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] mask_q;
    port_mode_e       mode_q;
    logic [WIDTH-1:0] pin_sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '1;
            mask_q <= '0;
            mode_q <= MODE_OD_RISE;
        end else if (wr_en) begin
            case (addr)
                ADR_DATA: data_q <= wdata;
                ADR_MASK: mask_q <= wdata;
                ADR_MODE: mode_q <= port_mode_e'(wdata[1:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADR_DATA: rd_data = pin_sync;
            ADR_MASK: rd_data = mask_q;
            ADR_MODE: rd_data = {{MODE_PAD{1'b0}}, mode_q};
            default:  rd_data = '0;
        endcase
    end

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_pad_ctl #(.WIDTH(WIDTH)) u_pad (
        .mode     (mode_q),
        .data     (data_q),
        .mask     (mask_q),
        .drv_low  (drv_low),
        .drv_high (drv_high),
        .pull_up  (pull_up)
    );

    gpio_edge_irq #(.WIDTH(WIDTH)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_q),
        .mask  (mask_q),
        .level (pin_sync),
        .irq   (irq)
    );
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] mask,
    input logic [WIDTH-1:0] level,
    input logic [WIDTH-1:0] drv_low,
    input logic [WIDTH-1:0] drv_high,
    input logic [WIDTH-1:0] pull_up,
    input logic             irq
);
    AST_NO_DRIVE_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_low & drv_high) == '0); // R2

    AST_PULL_ONLY_RESISTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b11) |-> (pull_up == '0)); // R3

    AST_HIGH_ONLY_PUSHPULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b10) |-> (drv_high == '0)); // R5

    AST_HIGH_OFF_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_high & mask) == '0); // R4

    AST_QUIET_PUSHPULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b10) |-> !irq); // R9

    AST_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask) == '0) |-> !irq); // R10

    AST_IRQ_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(level) != $past(level, 2))); // R7
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .mask     (mask_q),
    .level    (pin_sync),
    .drv_low  (drv_low),
    .drv_high (drv_high),
    .pull_up  (pull_up),
    .irq      (irq)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] rd_data, drv_low, drv_high, pull_up;
    logic       irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    typedef struct {
        string      tag;
        int         sel;
        logic [7:0] exp;
    } exp_t;
    exp_t sb[$];

    gpio_irq_port uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .pin_in(pin_in), .drv_low(drv_low),
        .drv_high(drv_high), .pull_up(pull_up), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pick(int sel);
        case (sel)
            0:       return rd_data;
            1:       return drv_low;
            2:       return drv_high;
            3:       return pull_up;
            default: return {7'b0, irq};
        endcase
    endfunction

    function automatic string sel_name(int sel);
        case (sel)
            0:       return "rd_data";
            1:       return "drv_low";
            2:       return "drv_high";
            3:       return "pull_up";
            default: return "irq";
        endcase
    endfunction

    // monitor: compares at the falling edge every item queued in this cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t it;
                logic [7:0] act;
                it  = sb.pop_front();
                act = pick(it.sel);
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s actual %h expected %h", it.tag,
                             sel_name(it.sel), act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic want(string tag, int sel, logic [7:0] e);
        exp_t it;
        it.tag = tag;
        it.sel = sel;
        it.exp = e;
        sb.push_back(it);
    endtask

    task automatic settle();
        wait (sb.size() == 0);
    endtask

    task automatic reg_wr(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic drive_expect(string tag, logic [7:0] lo, logic [7:0] hi,
                                logic [7:0] pu);
        want(tag, 1, lo);
        want(tag, 2, hi);
        want(tag, 3, pu);
        settle();
    endtask

    // change the pins, then watch irq over four cycles
    task automatic edge_window(string tag, logic [7:0] new_pins, bit fire);
        pin_in = new_pins;
        for (int t = 1; t <= 4; t++) begin
            tick();
            want(tag, 4, (fire && t == 3) ? 8'h01 : 8'h00);
            settle();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        pin_in = 8'hFF;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        drive_expect("R1 reset", 8'h00, 8'h00, 8'h00);
        want("R1 reset irq", 4, 8'h00);
        addr = 2'd1; want("R1 mask reset", 0, 8'h00); settle();
        addr = 2'd2; want("R1 mode reset", 0, 8'h00); settle();
        tick();
        addr = 2'd0; want("R6 pins after reset", 0, 8'hFF); settle();

        // R2/R5: open-drain, mode 00
        reg_wr(2'd0, 8'hA5);
        drive_expect("R2 R5 mode00", 8'h5A, 8'h00, 8'h00);
        reg_wr(2'd2, 8'h01);
        drive_expect("R5 mode01", 8'h5A, 8'h00, 8'h00);

        // R3: resistive
        reg_wr(2'd2, 8'h03);
        drive_expect("R3 resistive", 8'h5A, 8'h00, 8'hA5);

        // R4: push-pull, then mask on low nibble
        reg_wr(2'd2, 8'h02);
        drive_expect("R4 pushpull", 8'h5A, 8'hA5, 8'h00);
        reg_wr(2'd1, 8'h0F);
        drive_expect("R4 masked open-drain", 8'h5A, 8'hA0, 8'h00);

        // R11: readback and unused address
        reg_wr(2'd3, 8'h77);
        addr = 2'd3; want("R11 addr3 reads zero", 0, 8'h00); settle();
        addr = 2'd1; want("R11 mask readback", 0, 8'h0F); settle();
        addr = 2'd2; want("R11 mode readback", 0, 8'h02); settle();
        drive_expect("R11 addr3 write ignored", 8'h5A, 8'hA0, 8'h00);

        // R6 + R9: pins fall on masked bits in mode 10, no irq; read pins
        addr = 2'd0;
        pin_in = 8'h3C;
        tick();
        want("R6 one edge still old", 0, 8'hFF);
        want("R9 pushpull quiet", 4, 8'h00);
        settle();
        tick();
        want("R6 pins not data", 0, 8'h3C);
        want("R9 pushpull quiet", 4, 8'h00);
        settle();
        repeat (3) begin
            tick();
            want("R9 pushpull quiet", 4, 8'h00);
            settle();
        end

        // R7: rising edges in mode 00
        reg_wr(2'd2, 8'h00);
        reg_wr(2'd1, 8'h01);
        edge_window("R7 rise fires", 8'h3D, 1'b1);
        edge_window("R7 fall quiet", 8'h3C, 1'b0);

        // R10: unmasked pin
        edge_window("R10 unmasked rise", 8'hBC, 1'b0);

        // R8: falling polarity in modes 01 and 11
        reg_wr(2'd2, 8'h01);
        edge_window("R8 mode01 rise quiet", 8'hBD, 1'b0);
        edge_window("R8 mode01 fall fires", 8'hBC, 1'b1);
        reg_wr(2'd2, 8'h03);
        edge_window("R8 resistive rise quiet", 8'hBD, 1'b0);
        edge_window("R8 resistive fall fires", 8'hBC, 1'b1);
        edge_window("R10 unmasked fall", 8'h3C, 1'b0);

        tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule